// File: doc/BRIEF.md
# Field replay capture scheduler

This block sequences the capture and replay of main-picture video fields through an external field memory. It does not move pixels. It decides on which incoming fields one field is written to memory, and which memory slot is shown on each output field during replay. The memory is a ring of `SLOTS` field slots. While filling, the block keeps one field out of every N, where N is picked by a 2-bit acquire code. The slot written last becomes the newest, and once the ring is full the oldest slot is overwritten.

Filling is enabled by a keep-fill control, but only while every overlay-enable bit is zero. Clearing keep-fill freezes the ring, and no further writes happen. A replay request then walks the stored fields from the oldest to the newest and wraps back to the oldest. Each stored field is shown for `N << pb_code` output fields, so that slower playback stretches each field. Each write is a request that stays asserted until the memory controller acknowledges it.

Top module: `field_replay_sched`

## Requirements
- R1: After reset, `wr_req`, `wr_slot`, `rd_valid` and `rd_slot` are all zero.
- R2: While filling, the first field strobe after filling starts captures a field. After that, one field out of every N is captured, with N = 4, 6, 8, 10 for `acq_code` 00, 01, 10, 11. The strobe counter runs on the live code.
- R3: Captures go to consecutive slots, starting at slot 0 and wrapping from `SLOTS-1` to 0. The stored count saturates at `SLOTS`.
- R4: A set `keep_fill` has no effect while any bit of `overlay_en` is set. No write is requested.
- R5: While `keep_fill` is 0, no write is requested and `wr_slot` stays constant.
- R6: The acquire code is ignored while not filling. Replay pacing uses the code latched at the last capture.
- R7: On the first field strobe with `replay_go`=1, not filling, at least one stored field and no write pending, `rd_valid` rises and `rd_slot` is the oldest stored slot.
- R8: During replay, each slot is held for `N << pb_code` field strobes before `rd_slot` advances. `pb_code` 00, 01, 10, 11 gives 1x, 1/2, 1/4, 1/8 speed.
- R9: After the newest stored slot, replay wraps back to the oldest.
- R10: `wr_req` rises one cycle after a capturing strobe and stays high until the cycle after `wr_ack`. No new capture starts while a write is pending.
- R11: A field strobe with `replay_go`=0, or while filling, clears `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_strobe | input | 1 | One-cycle pulse at each field start |
| keep_fill | input | 1 | 1 = keep refilling memory, 0 = save and freeze |
| overlay_en | input | 4 | Overlay window enables; any set bit blocks filling |
| acq_code | input | 2 | Capture decimation code |
| pb_code | input | 2 | Playback slow-down code |
| replay_go | input | 1 | Replay request |
| wr_ack | input | 1 | Memory write completed |
| wr_req | output | 1 | Field write pending (busy) |
| wr_slot | output | $clog2(SLOTS) | Slot for the pending or next write |
| rd_valid | output | 1 | Replay is active |
| rd_slot | output | $clog2(SLOTS) | Slot to display |

## Verification
The first pattern asserts keep-fill with one overlay window enabled, and expects no writes. Filling then runs with code 00 and afterwards with code 11. This separates 1-in-4 from 1-in-10 decimation and pushes the write pointer past the ring end, which checks wrap and saturation. The ring is then frozen, and the acquire code is changed while frozen. Replay then runs at half speed, long enough to pass newest-to-oldest. Because the hold length is built from the latched code, a design that follows the live code advances at the wrong field. Finally, replay is stopped and filling is resumed to check that the read side drops out.

// File: rtl/frp_pkg.sv
package frp_pkg;
  // fields per captured field for a given acquire code
  function automatic logic [3:0] fields_per_cap(input logic [1:0] code);
    return 4'd4 + {1'b0, code, 1'b0};
  endfunction
endpackage

// File: rtl/frp_decim.sv
module frp_decim
  import frp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_strobe,
  input  logic       fill,
  input  logic [1:0] acq_code,
  input  logic       wr_busy,
  output logic       cap_go,
  output logic [1:0] acq_lat
);
  logic [3:0] phase_q, phase_d;
  logic [1:0] acq_d;
  logic [3:0] n_live;

  always_comb begin
    n_live  = fields_per_cap(acq_code);
    cap_go  = field_strobe && fill && (phase_q == 4'd0) && !wr_busy;
    phase_d = phase_q;
    acq_d   = acq_lat;
    if (field_strobe) begin
      if (!fill)                       phase_d = 4'd0;
      else if (phase_q >= n_live - 4'd1) phase_d = 4'd0;
      else                             phase_d = phase_q + 4'd1;
    end
    if (cap_go) acq_d = acq_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 4'd0;
      acq_lat <= 2'd0;
    end else begin
      phase_q <= phase_d;
      acq_lat <= acq_d;
    end
  end

  p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= 4'd9);
  p_no_cap_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fill |-> !cap_go);
endmodule

// File: rtl/frp_wr_ctrl.sv
module frp_wr_ctrl #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_go,
  input  logic          wr_ack,
  output logic          wr_pend,
  output logic [SW-1:0] wptr,
  output logic [CW-1:0] stored
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
  localparam logic [CW-1:0] FULL = CW'(SLOTS);

  logic          pend_d;
  logic [SW-1:0] wptr_d;
  logic [CW-1:0] stored_d;
  logic          done;

  always_comb begin
    done     = wr_pend && wr_ack;
    pend_d   = wr_pend;
    wptr_d   = wptr;
    stored_d = stored;
    if (cap_go) begin
      pend_d = 1'b1;
    end else if (done) begin
      pend_d = 1'b0;
      wptr_d = (wptr == LAST) ? '0 : wptr + 1'b1;
      if (stored != FULL) stored_d = stored + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend <= 1'b0;
      wptr    <= '0;
      stored  <= '0;
    end else begin
      wr_pend <= pend_d;
      wptr    <= wptr_d;
      stored  <= stored_d;
    end
  end

  p_stored_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stored <= FULL);
  p_ptr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_pend && wr_ack) |-> $stable(wptr));
  p_one_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend && !wr_ack |=> wr_pend);
endmodule

// File: rtl/frp_rd_sched.sv
module frp_rd_sched
  import frp_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1),
  localparam int HW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_strobe,
  input  logic          fill,
  input  logic          replay_go,
  input  logic [1:0]    pb_code,
  input  logic [1:0]    acq_lat,
  input  logic [SW-1:0] wptr,
  input  logic [CW-1:0] stored,
  input  logic          wr_pend,
  output logic          rd_valid,
  output logic [SW-1:0] rd_slot
);
  localparam logic [SW:0]   RING = (SW+1)'(SLOTS);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [HW-1:0] hold_q, hold_d, limit;
  logic          valid_d;
  logic [SW-1:0] slot_d, oldest, newest, step;
  logic [SW:0]   old_x;

  always_comb begin
    limit  = HW'({3'b000, fields_per_cap(acq_lat)} << pb_code);
    old_x  = {1'b0, wptr} + RING - (SW+1)'(stored);
    if (old_x >= RING) old_x = old_x - RING;
    oldest = old_x[SW-1:0];
    newest = (wptr == '0) ? LAST : wptr - 1'b1;
    step   = (rd_slot == newest) ? oldest
           : ((rd_slot == LAST) ? '0 : rd_slot + 1'b1);
    valid_d = rd_valid;
    slot_d  = rd_slot;
    hold_d  = hold_q;
    if (field_strobe) begin
      if (!fill && replay_go && stored != '0 && !wr_pend) begin
        valid_d = 1'b1;
        if (!rd_valid) begin
          slot_d = oldest;
          hold_d = HW'(1);
        end else if (hold_q >= limit) begin
          slot_d = step;
          hold_d = HW'(1);
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end else begin
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_slot  <= '0;
      hold_q   <= '0;
    end else begin
      rd_valid <= valid_d;
      rd_slot  <= slot_d;
      hold_q   <= hold_d;
    end
  end

  p_hold_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= HW'(80));
  p_slot_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_slot <= LAST);
  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    field_strobe && (fill || !replay_go) |=> !rd_valid);
endmodule

// File: rtl/field_replay_sched.sv
module field_replay_sched #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_strobe,
  input  logic          keep_fill,
  input  logic [3:0]    overlay_en,
  input  logic [1:0]    acq_code,
  input  logic [1:0]    pb_code,
  input  logic          replay_go,
  input  logic          wr_ack,
  output logic          wr_req,
  output logic [SW-1:0] wr_slot,
  output logic          rd_valid,
  output logic [SW-1:0] rd_slot
);
  logic          fill, cap_go, wr_pend;
  logic [1:0]    acq_lat;
  logic [CW-1:0] stored;

  assign fill   = keep_fill && (overlay_en == 4'd0);
  assign wr_req = wr_pend;

  frp_decim u_decim (
    .clk(clk), .rst_n(rst_n), .field_strobe(field_strobe), .fill(fill),
    .acq_code(acq_code), .wr_busy(wr_pend), .cap_go(cap_go), .acq_lat(acq_lat)
  );

  frp_wr_ctrl #(.SLOTS(SLOTS)) u_wr (
    .clk(clk), .rst_n(rst_n), .cap_go(cap_go), .wr_ack(wr_ack),
    .wr_pend(wr_pend), .wptr(wr_slot), .stored(stored)
  );

  frp_rd_sched #(.SLOTS(SLOTS)) u_rd (
    .clk(clk), .rst_n(rst_n), .field_strobe(field_strobe), .fill(fill),
    .replay_go(replay_go), .pb_code(pb_code), .acq_lat(acq_lat),
    .wptr(wr_slot), .stored(stored), .wr_pend(wr_pend),
    .rd_valid(rd_valid), .rd_slot(rd_slot)
  );

  p_write_needs_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(field_strobe && keep_fill && overlay_en == 4'd0));
  p_no_replay_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(replay_go && !fill));
endmodule

// File: tb/field_replay_sched_tb_top.sv
module field_replay_sched_tb_top;
  localparam int SLOTS = 8;
  localparam int SW = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_strobe = 1'b0, keep_fill = 1'b0, replay_go = 1'b0, wr_ack = 1'b0;
  logic [3:0] overlay_en = 4'd0;
  logic [1:0] acq_code = 2'd0, pb_code = 2'd0;
  logic wr_req, rd_valid;
  logic [SW-1:0] wr_slot, rd_slot;

  int checks = 0, failures = 0, writes = 0, ack_cnt = 0;
  int m_ph, m_pend, m_wp, m_st, m_acq, m_rv, m_rs, m_hold;
  bit done_run = 0;

  always #10 clk = ~clk;

  field_replay_sched #(.SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .field_strobe(field_strobe), .keep_fill(keep_fill),
    .overlay_en(overlay_en), .acq_code(acq_code), .pb_code(pb_code),
    .replay_go(replay_go), .wr_ack(wr_ack), .wr_req(wr_req), .wr_slot(wr_slot),
    .rd_valid(rd_valid), .rd_slot(rd_slot)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pend = 0; m_wp = 0; m_st = 0; m_acq = 0;
      m_rv = 0; m_rs = 0; m_hold = 0;
    end else begin
      bit fl, cap;
      int lim, oldest, newest;
      fl  = keep_fill && (overlay_en == 0);
      cap = field_strobe && fl && m_ph == 0 && m_pend == 0;
      if (field_strobe) begin
        if (!fl && replay_go && m_st != 0 && m_pend == 0) begin
          lim = (4 + 2 * m_acq) << pb_code;
          oldest = (m_wp - m_st + SLOTS) % SLOTS;
          newest = (m_wp + SLOTS - 1) % SLOTS;
          if (m_rv == 0) begin m_rv = 1; m_rs = oldest; m_hold = 1; end
          else if (m_hold >= lim) begin
            m_hold = 1;
            m_rs = (m_rs == newest) ? oldest : (m_rs + 1) % SLOTS;
          end else m_hold++;
        end else m_rv = 0;
        if (!fl) m_ph = 0;
        else m_ph = (m_ph >= 3 + 2 * acq_code) ? 0 : m_ph + 1;
      end
      if (wr_ack && m_pend == 1) begin
        m_pend = 0; m_wp = (m_wp + 1) % SLOTS;
        if (m_st < SLOTS) m_st++;
        writes++;
      end
      if (cap) begin m_pend = 1; m_acq = acq_code; end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 R2 wr_req", wr_req, m_pend);
      chk("R3 R5 wr_slot", wr_slot, m_wp);
      chk("R7 R11 rd_valid", rd_valid, m_rv);
      if (m_rv == 1) chk("R8 R9 R6 rd_slot", rd_slot, m_rs);
    end
  end

  // memory controller stand-in: acknowledges three cycles after a request
  always @(negedge clk) begin
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      ack_cnt++;
      if (ack_cnt == 3) begin wr_ack = 1'b1; ack_cnt = 0; end
    end
  end

  task automatic fields(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) field_strobe = 1'b1;
      @(negedge clk) field_strobe = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_req", wr_req, 0);
    chk("R1 wr_slot", wr_slot, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rd_slot", rd_slot, 0);
    rst_n = 1'b1;
    // R4: overlay enabled blocks filling
    overlay_en = 4'b0010; keep_fill = 1'b1;
    fields(20);
    chk("R4 writes", writes, 0);
    // R2: 1 of 4, then 1 of 10
    overlay_en = 4'd0; acq_code = 2'b00;
    fields(20);
    chk("R2 writes code00", writes, 5);
    acq_code = 2'b11;
    fields(40);
    chk("R2 writes code11", writes, 9);
    chk("R3 wrapped slot", wr_slot, 1);
    // R5 R6: frozen, acquire code changed
    keep_fill = 1'b0; acq_code = 2'b01;
    fields(30);
    chk("R5 writes frozen", writes, 9);
    chk("R5 slot frozen", wr_slot, 1);
    // R7 R8 R9: replay at half speed
    replay_go = 1'b1; pb_code = 2'b01;
    fields(1);
    chk("R7 rd_valid", rd_valid, 1);
    chk("R7 oldest slot", rd_slot, 1);
    fields(19);
    chk("R8 held slot", rd_slot, 1);
    fields(1);
    chk("R8 advanced slot", rd_slot, 2);
    fields(150);
    chk("R9 wrapped to oldest", rd_slot, 1);
    pb_code = 2'b00;
    fields(25);
    // R11: stop
    replay_go = 1'b0;
    fields(1);
    chk("R11 stopped", rd_valid, 0);
    replay_go = 1'b1; keep_fill = 1'b1;
    fields(6);
    chk("R11 fill blocks replay", rd_valid, 0);
    done_run = 1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule